// File: doc/BRIEF.md
# CAN Transmit Mailbox Scheduler

This block decides which of fifteen transmit mailboxes a CAN controller sends next. Host software marks mailboxes as waiting through a small register-style port. Each cycle, the block picks one waiting mailbox and offers it to a bus engine. The bus engine is abstracted here: it takes the offer, attempts the frame, and reports whether the frame went out cleanly or lost arbitration.

The selection policy is chosen by a mode pin. One policy serves the lowest mailbox number first. The other serves the smallest message identifier, and breaks a tie toward the lower mailbox number. The pick is recomputed every cycle until the engine accepts it, so a newly waiting mailbox with higher priority takes the place of the current candidate. The host can withdraw waiting mailboxes; each withdrawal is recorded in an abort flag. Each clean transmission sets a completion flag. Both flag sets are write-one-to-clear. They are combined through a per-mailbox mask and a global enable into one interrupt.

The offer side is a valid/ready pair. While `tx_valid` is high and `tx_ready` is low, the offered mailbox and identifier may change, or `tx_valid` may drop. This is intended: it is how reselection and cancellation take effect. The offer is binding only in the cycle where both are high. After that, `tx_valid` stays low until the engine answers on `res_valid`. Only one transfer is in flight at a time.

Top module: `can_tx_sched`

## Requirements
- R1: While reset is asserted, and right after it, every pending, completion, abort and mask bit is 0, and `tx_valid` and `irq` are low.
- R2: Bit i of `hw_data` refers to mailbox i+1. A host write with `hw_op`=0 sets the pending bits for the 1 bits in `hw_data` and leaves the other pending bits unchanged. Op codes 5 to 7 change nothing.
- R3: When `by_id`=0, `tx_mbox` is the lowest-numbered pending mailbox, numbered 1 to 15.
- R4: When `by_id`=1, the offered mailbox is the pending mailbox with the numerically smallest identifier. If two identifiers are equal, the lower mailbox number wins. Identifier k occupies `id_flat[k*11 +: 11]`.
- R5: The offer is recomputed every cycle the block is not busy. A pending bit written in one cycle can displace the candidate in the next cycle.
- R6: After a cycle with `tx_valid` and `tx_ready` both high, `tx_valid` stays low until a cycle with `res_valid` high.
- R7: A result with `res_ok`=1 clears the pending bit of the in-flight mailbox and sets its completion flag. Both changes appear after that clock edge.
- R8: A result with `res_ok`=0 leaves the mailbox pending. Selection is offered again in the next cycle.
- R9: A host write with `hw_op`=1 clears the pending bit and sets the abort flag of each addressed mailbox that is pending. It has no effect on a mailbox that is not pending. It also has no effect on the mailbox in flight, including in the cycle that mailbox is accepted.
- R10: `hw_op`=2 clears completion flags and `hw_op`=3 clears abort flags, for the 1 bits in `hw_data`. If a flag is set and cleared in the same cycle, the set wins.
- R11: `hw_op`=4 loads the mask register from `hw_data`. `irq` is high exactly when `irq_en` is high and some completion or abort flag has its mask bit set.
- R12: `tx_id` carries the identifier of the mailbox shown on `tx_mbox`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_en | input | 1 | Host write strobe |
| hw_op | input | 3 | Host operation code (0 to 4) |
| hw_data | input | 15 | Per-mailbox bit vector for the operation |
| id_flat | input | 165 | Packed identifiers, 11 bits per mailbox |
| by_id | input | 1 | 1 selects identifier priority, 0 selects mailbox-number priority |
| irq_en | input | 1 | Global enable for the mailbox-empty interrupt |
| tx_valid | output | 1 | A mailbox is offered to the bus engine |
| tx_ready | input | 1 | Bus engine takes the offer |
| tx_mbox | output | 4 | Offered mailbox number, 1 to 15 |
| tx_id | output | 11 | Identifier of the offered mailbox |
| res_valid | input | 1 | Bus engine reports the result of the transfer in flight |
| res_ok | input | 1 | 1 means sent cleanly, 0 means arbitration lost |
| pend_o | output | 15 | Pending bits |
| ack_o | output | 15 | Completion flags |
| abk_o | output | 15 | Abort flags |
| mask_o | output | 15 | Interrupt mask bits |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume the bus engine answers only while a transfer is in flight, and answers exactly once per accepted offer. A stray `res_valid` is ignored by the design, but it would make the cause-and-effect properties on the flags hard to read. The bench keeps this contract by tracking in its model whether a transfer is outstanding. It raises `res_valid` only when one is, and it lets `tx_ready` toggle freely. Identifiers are drawn from a narrow range, so ties under identifier priority occur often.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;
  typedef enum logic [2:0] {
    OP_SET_PEND = 3'd0,
    OP_CANCEL   = 3'd1,
    OP_CLR_ACK  = 3'd2,
    OP_CLR_ABK  = 3'd3,
    OP_WR_MASK  = 3'd4
  } host_op_e;
endpackage

// File: rtl/can_tx_flag_bank.sv
// Bank of set/clear flags; set wins over clear in the same cycle.
module can_tx_flag_bank #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_v,
  input  logic [W-1:0] clr_v,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= (bit_q & ~clr_v[g]) | set_v[g];
    end
    assign q[g] = bit_q;
  end
endmodule

// File: rtl/can_tx_pick.sv
// Chooses one pending mailbox: first pending one (R3), or smallest id,
// with a tie going to the lower index (R4).
module can_tx_pick #(
  parameter int NMB = 15,
  parameter int IDW = 11,
  parameter int IXW = 4
) (
  input  logic [NMB-1:0]     pend,
  input  logic [NMB*IDW-1:0] ids,
  input  logic               by_id,
  output logic               any,
  output logic [IXW-1:0]     win_ix,
  output logic [IDW-1:0]     win_id
);
  always_comb begin
    any    = 1'b0;
    win_ix = '0;
    win_id = '0;
    for (int i = 0; i < NMB; i++) begin
      if (pend[i] && (!any || (by_id && (ids[i*IDW +: IDW] < win_id)))) begin
        any    = 1'b1;
        win_ix = IXW'(i);
        win_id = ids[i*IDW +: IDW];
      end
    end
  end
endmodule

// File: rtl/can_tx_sched.sv
module can_tx_sched
  import can_tx_pkg::*;
#(
  parameter int NMB = 15,
  parameter int IDW = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hw_en,
  input  logic [2:0]                 hw_op,
  input  logic [NMB-1:0]             hw_data,
  input  logic [NMB*IDW-1:0]         id_flat,
  input  logic                       by_id,
  input  logic                       irq_en,
  output logic                       tx_valid,
  input  logic                       tx_ready,
  output logic [$clog2(NMB+1)-1:0]   tx_mbox,
  output logic [IDW-1:0]             tx_id,
  input  logic                       res_valid,
  input  logic                       res_ok,
  output logic [NMB-1:0]             pend_o,
  output logic [NMB-1:0]             ack_o,
  output logic [NMB-1:0]             abk_o,
  output logic [NMB-1:0]             mask_o,
  output logic                       irq
);
  localparam int MBW = $clog2(NMB+1);
  localparam int IXW = (NMB > 1) ? $clog2(NMB) : 1;

  host_op_e op;
  assign op = host_op_e'(hw_op);

  logic w_set, w_cancel, w_clr_ack, w_clr_abk, w_mask;
  assign w_set     = hw_en && (op == OP_SET_PEND);
  assign w_cancel  = hw_en && (op == OP_CANCEL);
  assign w_clr_ack = hw_en && (op == OP_CLR_ACK);
  assign w_clr_abk = hw_en && (op == OP_CLR_ABK);
  assign w_mask    = hw_en && (op == OP_WR_MASK);

  logic           busy;
  logic [IXW-1:0] cur_ix;
  logic           any;
  logic [IXW-1:0] win_ix;
  logic [IDW-1:0] win_id;

  can_tx_pick #(.NMB(NMB), .IDW(IDW), .IXW(IXW)) u_pick (
    .pend(pend_o), .ids(id_flat), .by_id(by_id),
    .any(any), .win_ix(win_ix), .win_id(win_id)
  );

  assign tx_valid = any && !busy;
  assign tx_mbox  = MBW'(win_ix) + MBW'(1);
  assign tx_id    = win_id;

  logic accept, done_any, done_ok;
  assign accept   = tx_valid && tx_ready;
  assign done_any = busy && res_valid;
  assign done_ok  = done_any && res_ok;

  // Mailbox shielded from cancel: the one in flight or being accepted (R9)
  logic [NMB-1:0] inflight, ok_oh, cancel_hit;
  assign inflight   = busy ? (NMB'(1) << cur_ix) : (accept ? (NMB'(1) << win_ix) : '0);
  assign ok_oh      = done_ok ? (NMB'(1) << cur_ix) : '0;
  assign cancel_hit = w_cancel ? (hw_data & pend_o & ~inflight) : '0;

  can_tx_flag_bank #(.W(NMB)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_v(w_set ? hw_data : '0), .clr_v(ok_oh | cancel_hit), .q(pend_o)
  );
  can_tx_flag_bank #(.W(NMB)) u_ack (
    .clk(clk), .rst_n(rst_n),
    .set_v(ok_oh), .clr_v(w_clr_ack ? hw_data : '0), .q(ack_o)
  );
  can_tx_flag_bank #(.W(NMB)) u_abk (
    .clk(clk), .rst_n(rst_n),
    .set_v(cancel_hit), .clr_v(w_clr_abk ? hw_data : '0), .q(abk_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      busy   <= 1'b0;
      cur_ix <= '0;
    end else begin
      if (w_mask) mask_o <= hw_data;
      if (accept) begin
        busy   <= 1'b1;
        cur_ix <= win_ix;
      end else if (done_any) begin
        busy <= 1'b0;
      end
    end
  end

  assign irq = irq_en && (|((ack_o | abk_o) & mask_o));

  // One transfer outstanding at a time
  p_single_xfer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !tx_valid);
  // Lost arbitration leaves work pending and re-offers next cycle
  p_lost_reoffer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && res_valid && !res_ok) |=> tx_valid);
  // A completion flag rises only after a clean result
  p_ack_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_o & ~$past(ack_o))) |-> $past(res_valid && res_ok));
  // An abort flag rises only after a cancel write
  p_abk_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(abk_o & ~$past(abk_o))) |-> $past(hw_en && (hw_op == 3'd1)));
  // Pending bits drop only through success or cancel
  p_pend_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(pend_o) & ~pend_o)) |-> $past((busy && res_valid && res_ok) || (hw_en && (hw_op == 3'd1))));
  // Interrupt needs the global enable and some mask bit
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && (|mask_o)));
  // The offer names a pending mailbox (R3, R4)
  p_offer_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> pend_o[win_ix]);
endmodule

// File: tb/sim_can_tx_sched.sv
`timescale 1ns/1ps
module sim_can_tx_sched;
  localparam int NMB = 15;
  localparam int IDW = 11;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst_n;
  logic               hw_en;
  logic [2:0]         hw_op;
  logic [NMB-1:0]     hw_data;
  logic [NMB*IDW-1:0] id_flat;
  logic               by_id, irq_en, tx_ready, res_valid, res_ok;
  logic               tx_valid, irq;
  logic [3:0]         tx_mbox;
  logic [IDW-1:0]     tx_id;
  logic [NMB-1:0]     pend_o, ack_o, abk_o, mask_o;

  can_tx_sched u0 (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .hw_op(hw_op), .hw_data(hw_data),
    .id_flat(id_flat), .by_id(by_id), .irq_en(irq_en), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_mbox(tx_mbox), .tx_id(tx_id), .res_valid(res_valid),
    .res_ok(res_ok), .pend_o(pend_o), .ack_o(ack_o), .abk_o(abk_o),
    .mask_o(mask_o), .irq(irq)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  string scen = "reset";

  // Reference model state
  logic [NMB-1:0] m_pend = '0, m_ack = '0, m_abk = '0, m_mask = '0;
  bit m_busy = 0;
  int m_cur = 0;

  function automatic int id_of(int k);
    return int'(id_flat[k*IDW +: IDW]);
  endfunction

  // Expected winner index, -1 when nothing is pending
  function automatic int ref_pick();
    int best = -1;
    int low = 1 << IDW;
    if (!by_id) begin
      for (int k = NMB-1; k >= 0; k--) if (m_pend[k]) best = k;
    end else begin
      for (int k = 0; k < NMB; k++) if (m_pend[k] && id_of(k) < low) low = id_of(k);
      for (int k = NMB-1; k >= 0; k--) if (m_pend[k] && id_of(k) == low) best = k;
    end
    return best;
  endfunction

  task automatic chk(string req, string nm, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h", req, scen, nm, act, exp);
    end
  endtask

  task automatic compare();
    int w = ref_pick();
    bit ev = !m_busy && (w >= 0);
    bit ei = irq_en && (|((m_ack | m_abk) & m_mask));
    chk("R6", "tx_valid", tx_valid, ev);
    if (ev) begin
      chk(by_id ? "R4" : "R3", "tx_mbox", tx_mbox, w + 1);
      chk("R12", "tx_id", tx_id, id_of(w));
    end
    chk("R2", "pend_o", pend_o, m_pend);
    chk("R7", "ack_o", ack_o, m_ack);
    chk("R9", "abk_o", abk_o, m_abk);
    chk("R11", "mask_o", mask_o, m_mask);
    chk("R11", "irq", irq, ei);
  endtask

  task automatic update();
    int w = ref_pick();
    bit acc = !m_busy && (w >= 0) && tx_ready;
    logic [NMB-1:0] okv = '0, canc = '0, setv = '0, cack = '0, cabk = '0;
    if (m_busy && res_valid && res_ok) okv[m_cur] = 1'b1;
    if (hw_en) begin
      case (hw_op)
        3'd0: setv = hw_data;
        3'd1: for (int k = 0; k < NMB; k++)
                if (hw_data[k] && m_pend[k] && !((m_busy && m_cur == k) || (acc && w == k)))
                  canc[k] = 1'b1;
        3'd2: cack = hw_data;
        3'd3: cabk = hw_data;
        3'd4: m_mask = hw_data;
        default: ;
      endcase
    end
    m_pend = (m_pend & ~(okv | canc)) | setv;
    m_ack  = (m_ack & ~cack) | okv;
    m_abk  = (m_abk & ~cabk) | canc;
    if (acc) begin m_busy = 1; m_cur = w; end
    else if (m_busy && res_valid) m_busy = 0;
  endtask

  task automatic cyc();
    #1 compare();
    @(posedge clk);
    update();
    @(negedge clk);
    hw_en = 0; tx_ready = 0; res_valid = 0; res_ok = 0;
  endtask

  task automatic host(int op, logic [NMB-1:0] d);
    hw_en = 1; hw_op = 3'(op); hw_data = d;
    cyc();
  endtask

  task automatic set_id(int k, int v);
    id_flat[k*IDW +: IDW] = IDW'(v);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; hw_en = 0; hw_op = 0; hw_data = '0; by_id = 0; irq_en = 0;
    tx_ready = 0; res_valid = 0; res_ok = 0;
    for (int k = 0; k < NMB; k++) set_id(k, 100 + (NMB - k) * 3);
    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    chk("R1", "pend_o", pend_o, 0); chk("R1", "tx_valid", tx_valid, 0);
    chk("R1", "irq", irq, 0); chk("R1", "mask_o", mask_o, 0);
    @(negedge clk);
    rst_n = 1;
    cyc();
    chk("R1", "ack_o", ack_o, 0);

    scen = "R2 R3 number order";
    host(0, 15'b010_0000_0101_0000); cyc();
    host(5, 15'h7fff); cyc();           // op 5 ignored (R2)
    scen = "R5 newcomer wins";
    host(0, 15'b000_0000_0000_0100); cyc(); cyc();
    scen = "R4 id order with tie";
    by_id = 1; set_id(10, 7); set_id(14, 7); cyc();
    host(0, 15'b100_0000_0000_0000); cyc();
    scen = "R6 R7 clean send";
    irq_en = 1; host(4, 15'h7fff);
    tx_ready = 1; cyc(); cyc(); cyc();
    res_valid = 1; res_ok = 1; cyc(); cyc();
    scen = "R8 lost arbitration";
    tx_ready = 1; cyc(); cyc();
    res_valid = 1; res_ok = 0; cyc(); cyc();
    scen = "R9 cancel";
    tx_ready = 1; cyc();
    host(1, 15'h7fff); cyc();           // in-flight one survives
    host(1, 15'h7fff); cyc();           // nothing left but in-flight
    res_valid = 1; res_ok = 1; cyc(); cyc();
    scen = "R10 flag clear";
    host(2, 15'h7fff); host(3, 15'h0003); host(3, 15'h7fff); cyc();
    scen = "R11 mask and enable";
    host(0, 15'h0001); tx_ready = 1; cyc();
    res_valid = 1; res_ok = 1; cyc();
    host(4, 15'h0000); irq_en = 0; cyc(); host(4, 15'h0001); cyc(); irq_en = 1; cyc();

    scen = "random R2-mix";
    for (int t = 0; t < 6000; t++) begin
      if (($urandom % 50) == 0) by_id = ~by_id;
      if (($urandom % 40) == 0) irq_en = ~irq_en;
      if (($urandom % 30) == 0) set_id($urandom % NMB, $urandom % 6);
      if (($urandom % 3) == 0) begin
        hw_en = 1;
        hw_op = 3'($urandom % 7);
        hw_data = NMB'($urandom) & NMB'($urandom);
      end
      tx_ready = ($urandom % 3) != 0;
      if (m_busy && ($urandom % 3) == 0) begin
        res_valid = 1;
        res_ok = ($urandom % 4) != 0;
      end
      cyc();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule